// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits behind a receive MAC and decides, for every incoming Ethernet frame, whether the frame is kept or dropped on the strength of its 48-bit destination address alone. The MAC raises a start-of-frame strobe and then streams the six address bytes, one per accepted `byteValid` cycle, with idle cycles allowed between them. The block folds each byte into a running CRC-32 and, in parallel, shifts it into an address register.

When the sixth byte arrives, the block walks a small decision tree. An individual (unicast) address is first compared with the programmed station address. If that fails, the block consults a 64-bit individual hash table. A group (multicast) address is first compared with the reserved flow-control pause address, and this test only counts when flow control is enabled. If that fails, the block consults a separate 64-bit group hash table. The hash index is the top six bits of the CRC. The result is presented as a one-cycle verdict strobe with an accept flag.

Top module: `dest_addr_filter`

## Requirements
- R1: While reset is held, and after it is released until a verdict is produced, `verdictValid` and `verdictAccept` are 0.
- R2: The first address byte after a start-of-frame strobe occupies address bits 47:40 and the sixth occupies bits 7:0. `verdictValid` is high for exactly one cycle: the cycle after the clock edge that takes the sixth byte. `verdictAccept` is 0 whenever `verdictValid` is 0.
- R3: The hash is a CRC-32 with polynomial 0x04C11DB7, preset to all ones on start-of-frame, no final inversion. The six bytes are shifted in first byte first, each byte least significant bit first. The hash index is CRC bits 31:26.
- R4: Each hash table is a 64-bit value {upper word, lower word}. Index bit 5 = 1 selects the upper word, and index bits 4:0 select the bit inside the selected word. All 64 indices are reachable in both tables.
- R5: An individual address (bit 40 = 0) that equals `stationAddr` is accepted whatever the table contents are.
- R6: An individual address that does not equal `stationAddr` is accepted exactly when its bit in the individual table is 1.
- R7: The group address 01-80-C2-00-00-01 is accepted when `flowCtlEn` is 1, whatever the table contents are.
- R8: When `flowCtlEn` is 0, the pause address is decided by the group table only.
- R9: A group address (bit 40 = 1) is never decided by the station address or by the individual table. Any group address other than the accepted pause case is accepted exactly when its group table bit is 1.
- R10: A start-of-frame strobe discards any partial address. A byte presented in the same cycle as the strobe is ignored. Bytes after the sixth, and bytes presented before any start-of-frame strobe, produce no verdict.
- R11: Idle cycles (`byteValid` = 0) between address bytes do not change the verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sofStrobe | input | 1 | Start of a new frame; restarts address collection |
| byteValid | input | 1 | `byteData` carries an address byte this cycle |
| byteData | input | 8 | Destination address byte |
| stationAddr | input | 48 | Programmed station address, first byte in bits 47:40 |
| indHashHi | input | 32 | Individual hash table, indices 32..63 |
| indHashLo | input | 32 | Individual hash table, indices 0..31 |
| grpHashHi | input | 32 | Group hash table, indices 32..63 |
| grpHashLo | input | 32 | Group hash table, indices 0..31 |
| flowCtlEn | input | 1 | Enables acceptance of the pause address |
| verdictValid | output | 1 | One-cycle strobe marking a verdict |
| verdictAccept | output | 1 | 1 = keep the frame, valid with `verdictValid` |

## Verification
The bench builds the block with its default configuration: six address bytes, a 32-bit CRC and a 6-bit hash. With only 64 table positions, the sweep keeps drawing addresses until every index has been hit through both the individual and the group path. Each address runs twice: once with only its own bit set in the table under test, and once with every other bit set. The unused table is loaded with the opposite pattern. This pins down both the CRC arithmetic and the half/bit selection for every table position. Directed frames then cover the exact-match, pause-address, aborted-frame, idle-gap and byte-order cases.

// File: rtl/daf_pkg.sv
package daf_pkg;
  localparam int BYTE_W     = 8;
  localparam int ADDR_BYTES = 6;
  localparam int ADDR_W     = BYTE_W * ADDR_BYTES;
  localparam int CRC_W      = 32;
  localparam int HASH_W     = 6;
  localparam int HALF_W     = 2 ** (HASH_W - 1);
  localparam int TABLE_W    = 2 * HALF_W;
  localparam int IG_BIT     = ADDR_W - BYTE_W;
  localparam logic [CRC_W-1:0]  CRC_POLY   = 32'h04C11DB7;
  localparam logic [ADDR_W-1:0] PAUSE_ADDR = 48'h0180C2000001;

  typedef struct packed {
    logic clearAddr;
    logic takeByte;
    logic lastByte;
  } ctrlStrobes_t;

  typedef enum logic [1:0] {
    PATH_EXACT,
    PATH_IND_HASH,
    PATH_PAUSE,
    PATH_GRP_HASH
  } decisionPath_t;
endpackage

// File: rtl/daf_ctrl.sv
module daf_ctrl
  import daf_pkg::*;
#(
  parameter int N_BYTES = ADDR_BYTES
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         sofStrobe,
  input  logic         byteValid,
  output ctrlStrobes_t strobes
);
  localparam int CW = $clog2(N_BYTES + 1);

  logic          armed;
  logic [CW-1:0] byteCnt;

  always_comb begin
    strobes.clearAddr = sofStrobe;
    strobes.takeByte  = armed && byteValid && !sofStrobe;
    strobes.lastByte  = strobes.takeByte && (byteCnt == CW'(N_BYTES - 1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed   <= 1'b0;
      byteCnt <= '0;
    end else if (sofStrobe) begin
      armed   <= 1'b1;
      byteCnt <= '0;
    end else if (strobes.takeByte) begin
      byteCnt <= byteCnt + 1'b1;
      if (strobes.lastByte) armed <= 1'b0;
    end
  end

  // R10
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    armed |-> (byteCnt < CW'(N_BYTES)));

  // R2
  last_disarm_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.lastByte && !sofStrobe |=> !armed);
endmodule

// File: rtl/daf_datapath.sv
module daf_datapath
  import daf_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strobes,
  input  logic [BYTE_W-1:0]  byteData,
  input  logic [ADDR_W-1:0]  stationAddr,
  input  logic [HALF_W-1:0]  indHashHi,
  input  logic [HALF_W-1:0]  indHashLo,
  input  logic [HALF_W-1:0]  grpHashHi,
  input  logic [HALF_W-1:0]  grpHashLo,
  input  logic               flowCtlEn,
  output logic               verdictValid,
  output logic               verdictAccept
);
  localparam int N_TABLES = 2;

  logic [ADDR_W-1:0] addrReg, addrNext;
  logic [CRC_W-1:0]  crcReg, crcNext;
  logic [HASH_W-1:0] hashIdx;
  logic [N_TABLES-1:0][TABLE_W-1:0] tables;
  logic [N_TABLES-1:0] tableHit;
  logic isGroup, exactHit, pauseHit, acceptNext;
  decisionPath_t path;

  function automatic logic [CRC_W-1:0] crcStep(input logic [CRC_W-1:0] c,
                                               input logic [BYTE_W-1:0] b);
    logic [CRC_W-1:0] r;
    logic fb;
    r = c;
    for (int i = 0; i < BYTE_W; i++) begin
      fb = r[CRC_W-1] ^ b[i];
      r  = {r[CRC_W-2:0], 1'b0};
      if (fb) r = r ^ CRC_POLY;
    end
    return r;
  endfunction

  always_comb begin
    addrNext = {addrReg[ADDR_W-BYTE_W-1:0], byteData};
    crcNext  = crcStep(crcReg, byteData);
    hashIdx  = crcNext[CRC_W-1 -: HASH_W];
  end

  assign tables[0] = {indHashHi, indHashLo};
  assign tables[1] = {grpHashHi, grpHashLo};

  for (genvar t = 0; t < N_TABLES; t++) begin : g_lookup
    assign tableHit[t] = tables[t][hashIdx];
  end

  always_comb begin
    isGroup  = addrNext[IG_BIT];
    exactHit = (addrNext == stationAddr);
    pauseHit = (addrNext == PAUSE_ADDR) && flowCtlEn;
    if (!isGroup) path = exactHit ? PATH_EXACT : PATH_IND_HASH;
    else          path = pauseHit ? PATH_PAUSE : PATH_GRP_HASH;
    unique case (path)
      PATH_EXACT,
      PATH_PAUSE:    acceptNext = 1'b1;
      PATH_IND_HASH: acceptNext = tableHit[0];
      PATH_GRP_HASH: acceptNext = tableHit[1];
      default:       acceptNext = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      crcReg  <= '1;
      addrReg <= '0;
    end else if (strobes.clearAddr) begin
      crcReg  <= '1;
      addrReg <= '0;
    end else if (strobes.takeByte) begin
      crcReg  <= crcNext;
      addrReg <= addrNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      verdictValid  <= 1'b0;
      verdictAccept <= 1'b0;
    end else begin
      verdictValid  <= strobes.lastByte;
      verdictAccept <= strobes.lastByte && acceptNext;
    end
  end

  // R3
  crc_preset_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clearAddr |=> (crcReg == '1));

  // R2
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    verdictValid |=> !verdictValid);

  // R5
  exact_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.lastByte && !addrNext[IG_BIT] && (addrNext == stationAddr)
      |=> verdictValid && verdictAccept);

  // R7
  pause_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.lastByte && flowCtlEn && (addrNext == PAUSE_ADDR)
      |=> verdictValid && verdictAccept);

  // R10
  sof_no_verdict_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clearAddr |=> !verdictValid);
endmodule

// File: rtl/dest_addr_filter.sv
module dest_addr_filter
  import daf_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               sofStrobe,
  input  logic               byteValid,
  input  logic [BYTE_W-1:0]  byteData,
  input  logic [ADDR_W-1:0]  stationAddr,
  input  logic [HALF_W-1:0]  indHashHi,
  input  logic [HALF_W-1:0]  indHashLo,
  input  logic [HALF_W-1:0]  grpHashHi,
  input  logic [HALF_W-1:0]  grpHashLo,
  input  logic               flowCtlEn,
  output logic               verdictValid,
  output logic               verdictAccept
);
  ctrlStrobes_t strobes;

  daf_ctrl #(.N_BYTES(ADDR_BYTES)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .sofStrobe (sofStrobe),
    .byteValid (byteValid),
    .strobes   (strobes)
  );

  daf_datapath uDp (
    .clk           (clk),
    .rstN          (rstN),
    .strobes       (strobes),
    .byteData      (byteData),
    .stationAddr   (stationAddr),
    .indHashHi     (indHashHi),
    .indHashLo     (indHashLo),
    .grpHashHi     (grpHashHi),
    .grpHashLo     (grpHashLo),
    .flowCtlEn     (flowCtlEn),
    .verdictValid  (verdictValid),
    .verdictAccept (verdictAccept)
  );

  // R1
  accept_qual_chk: assert property (@(posedge clk) disable iff (!rstN)
    verdictAccept |-> verdictValid);
endmodule

// File: tb/sim_dest_addr_filter.sv
module sim_dest_addr_filter;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sofStrobe = 1'b0;
  logic byteValid = 1'b0;
  logic [7:0]  byteData = '0;
  logic [47:0] stationAddr = 48'h021122334455;
  logic [31:0] indHashHi = '0, indHashLo = '0, grpHashHi = '0, grpHashLo = '0;
  logic flowCtlEn = 1'b0;
  logic verdictValid, verdictAccept;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  localparam logic [47:0] PAUSE = 48'h0180C2000001;

  always #5 clk = ~clk;

  dest_addr_filter u0 (
    .clk(clk), .rstN(rstN), .sofStrobe(sofStrobe), .byteValid(byteValid),
    .byteData(byteData), .stationAddr(stationAddr),
    .indHashHi(indHashHi), .indHashLo(indHashLo),
    .grpHashHi(grpHashHi), .grpHashLo(grpHashLo),
    .flowCtlEn(flowCtlEn), .verdictValid(verdictValid),
    .verdictAccept(verdictAccept)
  );

  function automatic logic [5:0] refHash(input logic [47:0] a);
    logic [31:0] r;
    r = '1;
    for (int k = 0; k < 6; k++) begin
      r = r ^ {24'b0, a[47-8*k -: 8]};
      for (int j = 0; j < 8; j++) r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    end
    return {r[0], r[1], r[2], r[3], r[4], r[5]};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic setTables(input logic [63:0] ind, input logic [63:0] grp);
    {indHashHi, indHashLo} = ind;
    {grpHashHi, grpHashLo} = grp;
  endtask

  // Drives the six bytes; returns at the negedge after the last byte is taken.
  task automatic sendAddr(input logic [47:0] a, input int gaps, input bit doSof);
    if (doSof) begin
      @(negedge clk); sofStrobe = 1'b1; byteValid = 1'b0;
      @(negedge clk); sofStrobe = 1'b0;
    end
    for (int k = 0; k < 6; k++) begin
      if ((gaps >> k) & 1) begin
        byteValid = 1'b0;
        @(negedge clk);
      end
      byteValid = 1'b1;
      byteData  = a[47-8*k -: 8];
      @(negedge clk);
    end
    byteValid = 1'b0;
  endtask

  task automatic expectVerdict(input string req, input bit expAcc);
    check({req, " valid"}, 64'(verdictValid), 64'd1);
    check({req, " accept"}, 64'(verdictAccept), 64'(expAcc));
    @(negedge clk);
    check({req, " pulse end"}, 64'({verdictValid, verdictAccept}), 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] lcg;
    logic [47:0] a;
    logic [63:0] one;
    logic [5:0]  h;
    bit [63:0] seenInd, seenGrp;

    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1 in reset", 64'({verdictValid, verdictAccept}), 64'd0);
    rstN = 1'b1;
    // bytes before any start-of-frame give nothing (R10)
    byteValid = 1'b1; byteData = 8'h02;
    repeat (8) begin
      @(negedge clk);
      check("R10 no sof", 64'(verdictValid), 64'd0);
    end
    byteValid = 1'b0;
    check("R1 after reset", 64'({verdictValid, verdictAccept}), 64'd0);

    // R5 exact match with empty tables, and with gaps (R11)
    setTables('0, '0);
    sendAddr(stationAddr, 0, 1'b1);  expectVerdict("R5 exact", 1'b1);
    sendAddr(stationAddr, 6'h3f, 1'b1); expectVerdict("R11 exact gaps", 1'b1);
    setTables('1, '1);
    sendAddr(stationAddr, 0, 1'b1);  expectVerdict("R5 exact full tables", 1'b1);

    // R6 near miss
    a = stationAddr ^ 48'h1;
    h = refHash(a);
    setTables('0, '1);
    sendAddr(a, 0, 1'b1);  expectVerdict("R6 miss", 1'b0);
    setTables(64'd1 << h, '0);
    sendAddr(a, 6'h15, 1'b1); expectVerdict("R6 hit", 1'b1);

    // R2 byte order: reversed station bytes rejected
    setTables('0, '0);
    a = {stationAddr[7:0], stationAddr[15:8], stationAddr[23:16],
         stationAddr[31:24], stationAddr[39:32], stationAddr[47:40]};
    a[40] = 1'b0;
    sendAddr(a, 0, 1'b1); expectVerdict("R2 byte order", 1'b0);

    // R7 / R8 pause address
    h = refHash(PAUSE);
    flowCtlEn = 1'b1; setTables('0, '0);
    sendAddr(PAUSE, 0, 1'b1); expectVerdict("R7 pause fce", 1'b1);
    flowCtlEn = 1'b0;
    setTables('1, ~(64'd1 << h));
    sendAddr(PAUSE, 0, 1'b1); expectVerdict("R8 pause no fce miss", 1'b0);
    setTables('0, 64'd1 << h);
    sendAddr(PAUSE, 0, 1'b1); expectVerdict("R8 pause no fce hit", 1'b1);

    // R9 group address equal to station is not exact-matched
    stationAddr = 48'h03AABBCCDDEE;
    setTables('1, '0);
    sendAddr(stationAddr, 0, 1'b1); expectVerdict("R9 group ignores station", 1'b0);
    stationAddr = 48'h021122334455;

    // R10 abort then restart
    setTables('0, '0);
    @(negedge clk); sofStrobe = 1'b1;
    @(negedge clk); sofStrobe = 1'b0;
    for (int k = 0; k < 3; k++) begin
      byteValid = 1'b1; byteData = 8'h77; @(negedge clk);
    end
    sendAddr(stationAddr, 0, 1'b1); expectVerdict("R10 abort restart", 1'b1);
    // byte alongside sof is ignored
    @(negedge clk); sofStrobe = 1'b1; byteValid = 1'b1; byteData = 8'hAA;
    @(negedge clk); sofStrobe = 1'b0;
    sendAddr(stationAddr, 0, 1'b0); expectVerdict("R10 byte with sof", 1'b1);
    // extra bytes produce no verdict
    byteValid = 1'b1; byteData = 8'h55;
    repeat (8) begin
      @(negedge clk);
      check("R10 extra bytes", 64'(verdictValid), 64'd0);
    end
    byteValid = 1'b0;

    // R3 / R4 / R6 / R9 sweep until all indices seen on both paths
    lcg = 64'h1234_5678_9ABC_DEF1;
    seenInd = '0; seenGrp = '0;
    for (int i = 0; i < 3000; i++) begin
      if (&seenInd && &seenGrp) break;
      lcg = lcg * 64'd6364136223846793005 + 64'd1442695040888963407;
      a = lcg[63:16];
      a[40] = i[0];
      if (a == stationAddr || a == PAUSE) a[0] = ~a[0];
      h = refHash(a);
      one = 64'd1 << h;
      flowCtlEn = lcg[3];
      if (!a[40]) begin
        seenInd[h] = 1'b1;
        setTables(one, ~one);
        sendAddr(a, i, 1'b1); expectVerdict("R3 R4 R6 ind hit", 1'b1);
        setTables(~one, one);
        sendAddr(a, i >> 3, 1'b1); expectVerdict("R3 R4 R6 ind miss", 1'b0);
      end else begin
        seenGrp[h] = 1'b1;
        setTables(~one, one);
        sendAddr(a, i, 1'b1); expectVerdict("R3 R4 R9 grp hit", 1'b1);
        setTables(one, ~one);
        sendAddr(a, i >> 3, 1'b1); expectVerdict("R3 R4 R9 grp miss", 1'b0);
      end
    end
    check("R4 ind coverage", seenInd, '1);
    check("R4 grp coverage", seenGrp, '1);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule